// File: doc/BRIEF.md
# Gamepad Mode and Watchdog Controller

This block holds the operating mode of a game controller that can run as a plain digital pad, as an analog pad, or in a configuration mode in which the host may change settings. It takes one strobe per finished host transaction, already-decoded host commands, a debounced press of the mode button on the pad, and a one-millisecond tick. From these it keeps the mode, the lamp, the analog-input enable, the rumble enable and the two identity bytes that the serial front end puts into each response.

A host that has once entered configuration mode also arms a communication watchdog. The watchdog stays armed when configuration mode is left. If no host transaction arrives for `TIMEOUT_MS` ticks, the controller returns to its power-up state: digital mode, lamp off, analog inputs off, rumble disabled, watchdog disarmed. A button press also turns the rumble off. If configuration mode was used earlier, a button press also changes the second header byte, so that the host can detect that the user changed the mode.

All outputs come from registers. An input that is present at a rising clock edge shows at the outputs right after that edge.

Top module: `pad_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (digital), `led`, `analog_en` and `rumble_en` are 0, `id_byte` is 41h and `hdr_byte` is 5Ah.
- R2: A pulse on `analog_btn` toggles between digital and analog mode. In analog mode `mode` is 1, `led` and `analog_en` are 1 and `id_byte` is 73h. In digital mode `id_byte` is 41h, the same value a plain digital pad reports. While the button pulse is present, all host commands of that cycle are ignored.
- R3: A pulse on `analog_btn` forces `rumble_en` to 0.
- R4: `cmd_cfg_enter` sets configuration mode (`mode` 2, `id_byte` F3h). `cmd_cfg_exit` in configuration mode returns `mode` to 0 or 1, according to the kept analog state. `led` and `analog_en` follow the analog state in every mode.
- R5: `cmd_analog_set` loads `cmd_analog_val` into the analog state only while in configuration mode. Outside it the command has no effect.
- R6: `cmd_rumble_set` loads `cmd_rumble_val` into `rumble_en` only while in configuration mode. Outside it the command has no effect, so after a lock the rumble stays off until the host enters configuration mode again and sets it.
- R7: `cmd_cfg_enter` arms the watchdog, and it stays armed after `cmd_cfg_exit`. When armed, the `TIMEOUT_MS`-th `ms_tick` with no `poll_strobe` (and no config entry) since the last one returns every output to its R1 value at that edge and disarms the watchdog.
- R8: `poll_strobe` or `cmd_cfg_enter` restarts the watchdog count, and wins over an `ms_tick` in the same cycle. An unarmed watchdog never times out.
- R9: `hdr_byte` changes from 5Ah to 00h on a button press only after configuration mode has been entered at least once. It returns to 5Ah on the next config entry or on a watchdog timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_strobe | input | 1 | One-cycle pulse per completed host transaction |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| analog_btn | input | 1 | One-cycle pulse per debounced mode button press |
| cmd_cfg_enter | input | 1 | Decoded host command: enter configuration mode |
| cmd_cfg_exit | input | 1 | Decoded host command: leave configuration mode |
| cmd_analog_set | input | 1 | Decoded host command: set analog state (config only) |
| cmd_analog_val | input | 1 | Value for cmd_analog_set |
| cmd_rumble_set | input | 1 | Decoded host command: set rumble enable (config only) |
| cmd_rumble_val | input | 1 | Value for cmd_rumble_set |
| mode | output | 2 | 0 digital, 1 analog, 2 configuration |
| led | output | 1 | Mode lamp, lit in analog state |
| analog_en | output | 1 | Analog stick inputs enabled |
| rumble_en | output | 1 | Rumble motors enabled (0 also means locked) |
| id_byte | output | 8 | Identity byte for responses |
| hdr_byte | output | 8 | Second response header byte |

## Verification
The hardest state to reach is a watchdog expiry that happens after configuration mode has already been left. It takes a config entry, an exit, then exactly `TIMEOUT_MS` ticks with no transaction. A single poll in between has to restart the window, and a poll that lands on the same cycle as the final tick has to prevent the expiry. The bench builds this sequence on purpose with a short timeout, tick by tick. It then runs long random stretches in which ticks are common and polls are rare, so that expiries land on top of button presses, header changes and pending commands.

// File: rtl/pad_mode_pkg.sv
package pad_mode_pkg;

    typedef enum logic [1:0] {
        MODE_DIGITAL = 2'd0,
        MODE_ANALOG  = 2'd1,
        MODE_CONFIG  = 2'd2
    } pad_mode_e;

    localparam logic [7:0] ID_DIGITAL = 8'h41;
    localparam logic [7:0] ID_ANALOG  = 8'h73;
    localparam logic [7:0] ID_CONFIG  = 8'hF3;
    localparam logic [7:0] HDR_NORMAL = 8'h5A;
    localparam logic [7:0] HDR_ALERT  = 8'h00;

    typedef struct packed {
        logic analog;    // analog state kept across config mode
        logic in_cfg;    // configuration mode active
        logic cfg_used;  // config entered since last power-up state
        logic hdr_alert; // header byte replaced
        logic rumble;    // rumble enabled
    } pad_state_t;

    localparam pad_state_t PAD_STATE_RESET = '{
        analog: 1'b0, in_cfg: 1'b0, cfg_used: 1'b0,
        hdr_alert: 1'b0, rumble: 1'b0
    };

    typedef struct packed {
        logic cfg_enter;
        logic cfg_exit;
        logic analog_set;
        logic analog_val;
        logic rumble_set;
        logic rumble_val;
    } pad_cmd_t;

    function automatic pad_mode_e mode_of(pad_state_t s);
        if (s.in_cfg)      return MODE_CONFIG;
        else if (s.analog) return MODE_ANALOG;
        else               return MODE_DIGITAL;
    endfunction

    function automatic logic [7:0] id_of(pad_mode_e m);
        case (m)
            MODE_CONFIG: return ID_CONFIG;
            MODE_ANALOG: return ID_ANALOG;
            default:     return ID_DIGITAL;
        endcase
    endfunction

endpackage

// File: rtl/pad_wdog.sv
module pad_wdog #(
    parameter int TIMEOUT_MS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic kick,
    input  logic tick,
    output logic armed,
    output logic fire
);
    localparam int CW = $clog2(TIMEOUT_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_MS - 1);

    logic [CW-1:0] cnt;

    assign fire = armed && tick && !kick && !arm && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || fire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else begin
            if (arm)
                armed <= 1'b1;
            if (kick || arm)
                cnt <= '0;
            else if (armed && tick)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pad_mode_core.sv
module pad_mode_core
    import pad_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_fire,
    input  logic       btn,
    input  pad_cmd_t   cmd,
    output pad_state_t st
);
    pad_state_t nx;

    always_comb begin
        nx = st;
        if (btn) begin
            nx.analog = ~st.analog;
            nx.rumble = 1'b0;
            if (st.cfg_used)
                nx.hdr_alert = 1'b1;
        end else begin
            if (cmd.cfg_enter) begin
                nx.in_cfg    = 1'b1;
                nx.cfg_used  = 1'b1;
                nx.hdr_alert = 1'b0;
            end else if (cmd.cfg_exit && st.in_cfg) begin
                nx.in_cfg = 1'b0;
            end
            if (st.in_cfg && cmd.analog_set)
                nx.analog = cmd.analog_val;
            if (st.in_cfg && cmd.rumble_set)
                nx.rumble = cmd.rumble_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wd_fire)
            st <= PAD_STATE_RESET;
        else
            st <= nx;
    end
endmodule

// File: rtl/pad_resp_fmt.sv
module pad_resp_fmt
    import pad_mode_pkg::*;
(
    input  pad_state_t  st,
    output logic [1:0]  mode,
    output logic        led,
    output logic        analog_en,
    output logic        rumble_en,
    output logic [7:0]  id_byte,
    output logic [7:0]  hdr_byte
);
    pad_mode_e m;

    always_comb begin
        m         = mode_of(st);
        mode      = m;
        led       = st.analog;
        analog_en = st.analog;
        rumble_en = st.rumble;
        id_byte   = id_of(m);
        hdr_byte  = st.hdr_alert ? HDR_ALERT : HDR_NORMAL;
    end
endmodule

// File: rtl/pad_mode_ctrl.sv
module pad_mode_ctrl
    import pad_mode_pkg::*;
#(
    parameter int TIMEOUT_MS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       poll_strobe,
    input  logic       ms_tick,
    input  logic       analog_btn,
    input  logic       cmd_cfg_enter,
    input  logic       cmd_cfg_exit,
    input  logic       cmd_analog_set,
    input  logic       cmd_analog_val,
    input  logic       cmd_rumble_set,
    input  logic       cmd_rumble_val,
    output logic [1:0] mode,
    output logic       led,
    output logic       analog_en,
    output logic       rumble_en,
    output logic [7:0] id_byte,
    output logic [7:0] hdr_byte
);
    pad_cmd_t   cmd;
    pad_state_t st;
    logic       wd_fire;
    logic       wd_armed;
    logic       cfg_take;

    // a button press masks the commands of its cycle, including the arm
    assign cfg_take = cmd_cfg_enter && !analog_btn;

    always_comb begin
        cmd.cfg_enter  = cmd_cfg_enter;
        cmd.cfg_exit   = cmd_cfg_exit;
        cmd.analog_set = cmd_analog_set;
        cmd.analog_val = cmd_analog_val;
        cmd.rumble_set = cmd_rumble_set;
        cmd.rumble_val = cmd_rumble_val;
    end

    pad_wdog #(.TIMEOUT_MS(TIMEOUT_MS)) u_wdog (
        .clk   (clk),
        .rst   (rst),
        .arm   (cfg_take),
        .kick  (poll_strobe),
        .tick  (ms_tick),
        .armed (wd_armed),
        .fire  (wd_fire)
    );

    pad_mode_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wd_fire (wd_fire),
        .btn     (analog_btn),
        .cmd     (cmd),
        .st      (st)
    );

    pad_resp_fmt u_fmt (
        .st        (st),
        .mode      (mode),
        .led       (led),
        .analog_en (analog_en),
        .rumble_en (rumble_en),
        .id_byte   (id_byte),
        .hdr_byte  (hdr_byte)
    );
endmodule

// File: rtl/pad_mode_ctrl_chk.sv
module pad_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       analog_btn,
    input logic [1:0] mode,
    input logic       led,
    input logic       analog_en,
    input logic       rumble_en,
    input logic [7:0] hdr_byte,
    input logic       wd_fire,
    input logic       wd_armed
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> mode == 2'd0 && !led && !rumble_en && hdr_byte == 8'h5A);

    p_btn_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        analog_btn && !wd_fire |=> analog_en != $past(analog_en));

    p_btn_rumble_off_r3: assert property (@(posedge clk) disable iff (rst)
        analog_btn |=> !rumble_en);

    p_rumble_rise_in_cfg_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rumble_en) |-> $past(mode) == 2'd2);

    p_timeout_clear_r7: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> mode == 2'd0 && !analog_en && !led && !rumble_en && !wd_armed);

    p_armed_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        wd_armed && !wd_fire |=> wd_armed);

    p_hdr_alert_cause_r9: assert property (@(posedge clk) disable iff (rst)
        hdr_byte == 8'h00 && $past(hdr_byte) == 8'h5A |-> $past(analog_btn));
endmodule

bind pad_mode_ctrl pad_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .analog_btn (analog_btn),
    .mode       (mode),
    .led        (led),
    .analog_en  (analog_en),
    .rumble_en  (rumble_en),
    .hdr_byte   (hdr_byte),
    .wd_fire    (wd_fire),
    .wd_armed   (wd_armed)
);

// File: tb/pad_mode_ctrl_bench.sv
module pad_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic poll_strobe = 0, ms_tick = 0, analog_btn = 0;
    logic cmd_cfg_enter = 0, cmd_cfg_exit = 0;
    logic cmd_analog_set = 0, cmd_analog_val = 0;
    logic cmd_rumble_set = 0, cmd_rumble_val = 0;
    logic [1:0] mode;
    logic led, analog_en, rumble_en;
    logic [7:0] id_byte, hdr_byte;

    int checks = 0;
    int errors = 0;
    int timeouts_seen = 0;

    // reference model state
    logic m_analog = 0, m_cfg = 0, m_used = 0, m_alert = 0, m_rumble = 0, m_armed = 0;
    int   m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_mode_ctrl #(.TIMEOUT_MS(TMO)) u_pad_mode_ctrl (
        .clk(clk), .rst(rst), .poll_strobe(poll_strobe), .ms_tick(ms_tick),
        .analog_btn(analog_btn), .cmd_cfg_enter(cmd_cfg_enter), .cmd_cfg_exit(cmd_cfg_exit),
        .cmd_analog_set(cmd_analog_set), .cmd_analog_val(cmd_analog_val),
        .cmd_rumble_set(cmd_rumble_set), .cmd_rumble_val(cmd_rumble_val),
        .mode(mode), .led(led), .analog_en(analog_en), .rumble_en(rumble_en),
        .id_byte(id_byte), .hdr_byte(hdr_byte)
    );

    function automatic logic [1:0] exp_mode();
        return m_cfg ? 2'd2 : (m_analog ? 2'd1 : 2'd0);
    endfunction

    function automatic logic [7:0] exp_id();
        return m_cfg ? 8'hF3 : (m_analog ? 8'h73 : 8'h41);
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({6'd0, mode}, {6'd0, exp_mode()}, {"R4 mode ", ctx});
        chk(id_byte, exp_id(), {"R2 id ", ctx});
        chk({7'd0, led}, {7'd0, m_analog}, {"R2 led ", ctx});
        chk({7'd0, analog_en}, {7'd0, m_analog}, {"R5 analog_en ", ctx});
        chk({7'd0, rumble_en}, {7'd0, m_rumble}, {"R6 rumble ", ctx});
        chk(hdr_byte, m_alert ? 8'h00 : 8'h5A, {"R9 hdr ", ctx});
    endtask

    // one clock with the given inputs; model updated from the requirements
    task automatic step(input logic poll, input logic tick, input logic btn,
                        input logic en, input logic ex, input logic as, input logic av,
                        input logic rs, input logic rv, input string ctx);
        logic take, fire;
        poll_strobe = poll; ms_tick = tick; analog_btn = btn;
        cmd_cfg_enter = en; cmd_cfg_exit = ex;
        cmd_analog_set = as; cmd_analog_val = av;
        cmd_rumble_set = rs; cmd_rumble_val = rv;
        @(posedge clk);
        take = en && !btn;
        fire = m_armed && tick && !poll && !take && (m_cnt == TMO - 1);
        if (fire) begin
            timeouts_seen++;
            m_analog = 0; m_cfg = 0; m_used = 0; m_alert = 0; m_rumble = 0;
            m_armed = 0; m_cnt = 0;
        end else begin
            if (take) m_armed = 1;
            if (poll || take) m_cnt = 0;
            else if (m_armed && tick) m_cnt++;
            if (btn) begin
                m_analog = !m_analog; m_rumble = 0;
                if (m_used) m_alert = 1;
            end else begin
                logic was_cfg;
                was_cfg = m_cfg;
                if (en) begin m_cfg = 1; m_used = 1; m_alert = 0; end
                else if (ex && was_cfg) m_cfg = 0;
                if (was_cfg && as) m_analog = av;
                if (was_cfg && rs) m_rumble = rv;
            end
        end
        @(negedge clk);
        poll_strobe = 0; ms_tick = 0; analog_btn = 0; cmd_cfg_enter = 0; cmd_cfg_exit = 0;
        cmd_analog_set = 0; cmd_rumble_set = 0;
        check_all(ctx);
    endtask

    task automatic idle(input string ctx);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, ctx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({6'd0, mode}, 8'd0, "R1 mode");
        chk(id_byte, 8'h41, "R1 id");
        chk(hdr_byte, 8'h5A, "R1 hdr");
        chk({7'd0, led | analog_en | rumble_en}, 8'd0, "R1 led/analog/rumble");

        // R8 unarmed: long silence does not time out
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 btn to analog");
        for (int i = 0; i < 3 * TMO; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 unarmed ticks");
        chk({7'd0, analog_en}, 8'd1, "R8 unarmed no timeout");
        // R9 button before config keeps 5A
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9 btn before cfg");
        chk(hdr_byte, 8'h5A, "R9 header before config");
        // R5/R6 ignored outside config
        step(0, 0, 0, 0, 0, 1, 1, 1, 1, "R5 R6 cmds outside cfg");
        chk({7'd0, analog_en}, 8'd0, "R5 analog set ignored");
        chk({7'd0, rumble_en}, 8'd0, "R6 rumble set ignored");
        // R4 enter config, set analog and rumble
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, "R4 enter");
        chk(id_byte, 8'hF3, "R4 config id");
        step(1, 0, 0, 0, 0, 1, 1, 1, 1, "R5 R6 in cfg");
        chk({7'd0, rumble_en}, 8'd1, "R6 rumble enabled in cfg");
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, "R4 exit");
        chk({6'd0, mode}, 8'd1, "R4 exit to analog");
        // R3 button locks rumble, R9 header drops
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R3 btn");
        chk({7'd0, rumble_en}, 8'd0, "R3 rumble locked");
        chk(hdr_byte, 8'h00, "R9 header after config use");
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9 reenter");
        chk(hdr_byte, 8'h5A, "R9 header restored on entry");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R6 reenable");
        step(0, 0, 0, 0, 1, 1, 1, 0, 0, "R4 exit with analog set");
        // R7 armed after exit: TMO-1 ticks, poll on final tick, then full window
        for (int i = 0; i < TMO - 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 ticks");
        chk({7'd0, analog_en}, 8'd1, "R7 not yet timed out");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R8 poll beats tick");
        chk({7'd0, analog_en}, 8'd1, "R8 poll restarts count");
        for (int i = 0; i < TMO - 1; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 ticks 2");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 final tick");
        chk({6'd0, mode}, 8'd0, "R7 timeout to digital");
        chk({7'd0, rumble_en | led}, 8'd0, "R7 rumble and led off");
        for (int i = 0; i < 2 * TMO; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 disarmed");
        idle("idle");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            step($urandom_range(0, 15) == 0, $urandom_range(0, 1) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
                 1'($urandom_range(0, 1)), $urandom_range(0, 7) == 0,
                 1'($urandom_range(0, 1)), "random");
        end
        checks++;
        if (timeouts_seen < 2) begin
            errors++;
            $display("FAIL R7 coverage: actual %0d timeouts expected at least 2", timeouts_seen);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule